// File: doc/BRIEF.md
# Segment Register Load and Limit Unit

This block loads a 16-bit selector into one of several segment registers. It reads the segment descriptor from memory, checks it, and keeps the result in the hidden part of the register. The selector picks a descriptor table and an entry in it. The unit reads the two 32-bit words of the descriptor over a simple request/acknowledge memory port. It then checks that the segment is present and that the requester has enough privilege. When the load succeeds, it writes the descriptor back with its accessed flag set, and then stores the selector, base, limit and attributes. When the load fails, it reports a fault code and leaves the register as it was.

After a load, the unit checks each memory access against the stored segment in the same cycle, without a new check. It scales the limit by the granularity flag, reverses the test for segments that grow downward, and forms the linear address. Privilege is checked only once, at load time. The current privilege level is taken from the selector held in segment register 0, the code register.

Top module: `seg_load_unit`

## Requirements
- R1: Selector bits 15:3 give the descriptor index, bit 2 picks the table (0 = global base input, 1 = local base input) and bits 1:0 give the requester privilege. The low descriptor word is read at table base + index*8, then the high word at that address + 4.
- R2: Low descriptor word: bits 31:16 hold base 15:0 and bits 15:0 hold limit 15:0. High word: 31:24 base 31:24, 23 granularity, 22 default size, 19:16 limit 19:16, 15 present, 14:13 descriptor privilege, 12 application flag, 11:8 type, 7:0 base 23:16.
- R3: If the present bit is clear, the load ends with fault code 1. The target register and the descriptor in memory are left unchanged.
- R4: The effective privilege is the numerically larger of the current level and the requester level. If it is numerically larger than the descriptor privilege, the load ends with fault code 2. The presence check comes first, so code 1 wins when both checks fail.
- R5: On success, the high word is written back with bit 8 (accessed) set. Then the target register takes the valid flag, the selector, the base and the limit. ld_done_o pulses for one cycle with ld_fault_o low and code 0, and the new register contents can be read in the same cycle.
- R6: The current privilege level is bits 1:0 of the selector held in segment register 0. It is 0 after reset.
- R7: With granularity 0, the limit counts bytes. With granularity 1, the effective limit is (limit << 12) | 0xFFF.
- R8: For an upward segment, an access is allowed when offset <= effective limit. The linear address is base + offset, modulo 2^32.
- R9: A segment grows downward when the application flag is 1, type bit 3 is 0 and type bit 2 is 1. For such a segment, an access is allowed only when offset > effective limit.
- R10: After reset, no register is valid, the unit is not busy, and every access check is refused.
- R11: A load request that arrives while a load is in progress is ignored.
- R12: A load request whose target index is 6 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gdt_base_i | input | 32 | Global table base address |
| ldt_base_i | input | 32 | Local table base address |
| ld_valid_i | input | 1 | Load request strobe |
| ld_seg_i | input | 3 | Target segment register index |
| ld_sel_i | input | 16 | Selector to load |
| ld_busy_o | output | 1 | Load in progress |
| ld_done_o | output | 1 | One-cycle load completion pulse |
| ld_fault_o | output | 1 | High with done when the load failed |
| ld_code_o | output | 2 | Result code: 0 ok, 1 absent, 2 privilege |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| acc_seg_i | input | 3 | Segment register selected for check and readback |
| acc_off_i | input | 32 | Access offset |
| acc_ok_o | output | 1 | Access is within the segment |
| acc_lin_o | output | 32 | Linear address |
| seg_valid_o | output | 1 | Selected register holds a loaded segment |
| seg_sel_o | output | 16 | Selected register selector |
| seg_base_o | output | 32 | Selected register base |
| seg_limit_o | output | 32 | Selected register effective limit |
| cpl_o | output | 2 | Current privilege level |

## Verification
A load takes three memory handshakes plus one check cycle, so memory wait states set its total length. The bench therefore waits for ld_done_o, one negative edge at a time, within a bounded window. It checks the code, the stored register and the descriptor in memory at the negative edge where the pulse is seen, because the register file and the pulse change on the same clock edge. The access check and readback are combinational: the bench applies the segment and offset at a negative edge and samples a moment later. A dropped request is confirmed by watching for a dozen cycles that neither busy nor done rises.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEL_W   = 16;
    localparam int IDX_W   = 13;
    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 20;
    localparam int GRAN_SH = 12;
    localparam int ACC_BIT = 8;
    localparam int HI_OFS  = 4;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PRIV   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_RD_LO,
        LD_RD_HI,
        LD_CHECK,
        LD_WR_HI
    } ld_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
        logic              dflt;
        logic              present;
        logic [1:0]        dpl;
        logic              app;
        logic [3:0]        kind;
    } desc_t;

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
        desc_t            desc;
    } seg_ent_t;

    // Split the two descriptor words into fields.
    function automatic desc_t desc_unpack(input logic [31:0] lo, input logic [31:0] hi);
        desc_t d;
        d.base    = {hi[31:24], hi[7:0], lo[31:16]};
        d.limit   = {hi[19:16], lo[15:0]};
        d.gran    = hi[23];
        d.dflt    = hi[22];
        d.present = hi[15];
        d.dpl     = hi[14:13];
        d.app     = hi[12];
        d.kind    = hi[11:8];
        return d;
    endfunction

    // Effective limit after granularity scaling.
    function automatic logic [ADDR_W-1:0] desc_span(input desc_t d);
        if (d.gran)
            return {d.limit, {GRAN_SH{1'b1}}};
        return {{(ADDR_W-LIM_W){1'b0}}, d.limit};
    endfunction

    function automatic logic desc_grows_down(input desc_t d);
        return d.app && !d.kind[3] && d.kind[2];
    endfunction

    function automatic logic [1:0] priv_weaker(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_pkg::*;
(
    input  logic [31:0] lo_i,
    input  logic [31:0] hi_i,
    input  logic [1:0]  cpl_i,
    input  logic [1:0]  rpl_i,
    output desc_t       desc_o,
    output fault_e      fault_o
);

    logic [1:0] eff_pl;

    assign desc_o = desc_unpack(lo_i, hi_i);
    assign eff_pl = priv_weaker(cpl_i, rpl_i);

    always_comb begin
        if (!desc_o.present)
            fault_o = FLT_ABSENT;
        else if (eff_pl > desc_o.dpl)
            fault_o = FLT_PRIV;
        else
            fault_o = FLT_NONE;
    end

endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SEG_W-1:0]  tgt_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] gdt_base_i,
    input  logic [ADDR_W-1:0] ldt_base_i,
    input  logic [1:0]        cpl_i,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic              wr_en_o,
    output logic [SEG_W-1:0]  wr_idx_o,
    output seg_ent_t          wr_ent_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [1:0]        code_o
);

    ld_state_e         st_q;
    logic [SEL_W-1:0]  sel_q;
    logic [SEG_W-1:0]  tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;
    logic [31:0]       hi_q;
    logic [1:0]        cpl_q;
    logic              done_q;
    fault_e            code_q;

    logic [ADDR_W-1:0] tbl_base;
    desc_t             chk_desc;
    fault_e            chk_fault;
    logic              tgt_ok;

    assign tbl_base = sel_i[2] ? ldt_base_i : gdt_base_i;
    assign tgt_ok   = (int'(tgt_i) < NUM_SEG);

    seg_desc_check u_check (
        .lo_i    (lo_q),
        .hi_i    (hi_q),
        .cpl_i   (cpl_q),
        .rpl_i   (sel_q[1:0]),
        .desc_o  (chk_desc),
        .fault_o (chk_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LD_IDLE;
            sel_q  <= '0;
            tgt_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            cpl_q  <= '0;
            done_q <= 1'b0;
            code_q <= FLT_NONE;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                LD_IDLE: begin
                    if (start_i && tgt_ok) begin
                        sel_q  <= sel_i;
                        tgt_q  <= tgt_i;
                        cpl_q  <= cpl_i;
                        code_q <= FLT_NONE;
                        addr_q <= tbl_base +
                                  {{(ADDR_W-IDX_W-3){1'b0}}, sel_i[SEL_W-1:3], 3'b000};
                        st_q   <= LD_RD_LO;
                    end
                end
                LD_RD_LO: begin
                    if (mem_ack_i) begin
                        lo_q <= mem_rdata_i;
                        st_q <= LD_RD_HI;
                    end
                end
                LD_RD_HI: begin
                    if (mem_ack_i) begin
                        hi_q <= mem_rdata_i;
                        st_q <= LD_CHECK;
                    end
                end
                LD_CHECK: begin
                    if (chk_fault != FLT_NONE) begin
                        code_q <= chk_fault;
                        done_q <= 1'b1;
                        st_q   <= LD_IDLE;
                    end else begin
                        st_q <= LD_WR_HI;
                    end
                end
                LD_WR_HI: begin
                    if (mem_ack_i) begin
                        done_q <= 1'b1;
                        st_q   <= LD_IDLE;
                    end
                end
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = addr_q;
        mem_wdata_o = hi_q | (32'd1 << ACC_BIT);
        case (st_q)
            LD_RD_LO: mem_req_o = 1'b1;
            LD_RD_HI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = addr_q + ADDR_W'(HI_OFS);
            end
            LD_WR_HI: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = addr_q + ADDR_W'(HI_OFS);
            end
            default: ;
        endcase
    end

    always_comb begin
        wr_ent_o              = '0;
        wr_ent_o.valid        = 1'b1;
        wr_ent_o.sel          = sel_q;
        wr_ent_o.desc         = chk_desc;
        wr_ent_o.desc.kind[0] = 1'b1;
    end

    assign wr_en_o  = (st_q == LD_WR_HI) && mem_ack_i;
    assign wr_idx_o = tgt_q;
    assign busy_o   = (st_q != LD_IDLE);
    assign done_o   = done_q;
    assign code_o   = code_q;
    assign fault_o  = done_q && (code_q != FLT_NONE);

endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
    import seg_pkg::*;
#(
    parameter int NUM_SEG  = 6,
    parameter int SEG_W    = 3,
    parameter int CODE_SEG = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [SEG_W-1:0]          wr_idx_i,
    input  seg_ent_t                  wr_ent_i,
    input  logic [SEG_W-1:0]          rd_idx_i,
    output seg_ent_t                  rd_ent_o,
    output logic [1:0]                cpl_o,
    output seg_ent_t [NUM_SEG-1:0]    bank_o
);

    seg_ent_t ents [NUM_SEG];

    generate
        for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)
                    ents[g] <= '0;
                else if (wr_en_i && (int'(wr_idx_i) == g))
                    ents[g] <= wr_ent_i;
            end
            assign bank_o[g] = ents[g];
        end
    endgenerate

    always_comb begin
        rd_ent_o = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(rd_idx_i) == i)
                rd_ent_o = ents[i];
        end
    end

    assign cpl_o = ents[CODE_SEG].sel[1:0];

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_pkg::*;
(
    input  seg_ent_t          ent_i,
    input  logic [ADDR_W-1:0] off_i,
    output logic              ok_o,
    output logic [ADDR_W-1:0] lin_o,
    output logic [ADDR_W-1:0] span_o
);

    logic down;

    assign span_o = desc_span(ent_i.desc);
    assign down   = desc_grows_down(ent_i.desc);
    assign lin_o  = ent_i.desc.base + off_i;

    always_comb begin
        if (!ent_i.valid)
            ok_o = 1'b0;
        else if (down)
            ok_o = (off_i > span_o);
        else
            ok_o = (off_i <= span_o);
    end

endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
#(
    parameter int NUM_SEG  = 6,
    parameter int CODE_SEG = 0,
    localparam int SEG_W   = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       gdt_base_i,
    input  logic [31:0]       ldt_base_i,
    input  logic              ld_valid_i,
    input  logic [SEG_W-1:0]  ld_seg_i,
    input  logic [15:0]       ld_sel_i,
    output logic              ld_busy_o,
    output logic              ld_done_o,
    output logic              ld_fault_o,
    output logic [1:0]        ld_code_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic [SEG_W-1:0]  acc_seg_i,
    input  logic [31:0]       acc_off_i,
    output logic              acc_ok_o,
    output logic [31:0]       acc_lin_o,
    output logic              seg_valid_o,
    output logic [15:0]       seg_sel_o,
    output logic [31:0]       seg_base_o,
    output logic [31:0]       seg_limit_o,
    output logic [1:0]        cpl_o
);

    logic                   wr_en;
    logic [SEG_W-1:0]       wr_idx;
    seg_ent_t               wr_ent;
    seg_ent_t               rd_ent;
    seg_ent_t [NUM_SEG-1:0] bank_all;
    logic [1:0]             cpl;

    seg_load_ctrl #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (ld_valid_i),
        .tgt_i       (ld_seg_i),
        .sel_i       (ld_sel_i),
        .gdt_base_i  (gdt_base_i),
        .ldt_base_i  (ldt_base_i),
        .cpl_i       (cpl),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .busy_o      (ld_busy_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_ent_o    (wr_ent),
        .done_o      (ld_done_o),
        .fault_o     (ld_fault_o),
        .code_o      (ld_code_o)
    );

    seg_reg_bank #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .CODE_SEG(CODE_SEG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_ent_i (wr_ent),
        .rd_idx_i (acc_seg_i),
        .rd_ent_o (rd_ent),
        .cpl_o    (cpl),
        .bank_o   (bank_all)
    );

    seg_limit_check u_lim (
        .ent_i  (rd_ent),
        .off_i  (acc_off_i),
        .ok_o   (acc_ok_o),
        .lin_o  (acc_lin_o),
        .span_o (seg_limit_o)
    );

    assign seg_valid_o = rd_ent.valid;
    assign seg_sel_o   = rd_ent.sel;
    assign seg_base_o  = rd_ent.desc.base;
    assign cpl_o       = cpl;

endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
    import seg_pkg::*;
#(
    parameter int NUM_SEG = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_done_o,
    input  logic                   ld_fault_o,
    input  logic [1:0]             ld_code_o,
    input  logic                   mem_req_o,
    input  logic                   mem_we_o,
    input  logic [31:0]            mem_wdata_o,
    input  logic                   mem_ack_i,
    input  logic                   ld_busy_o,
    input  logic                   acc_ok_o,
    input  logic                   seg_valid_o,
    input  seg_ent_t [NUM_SEG-1:0] bank
);

    p_fault_has_code_r3: assert property (@(posedge clk) disable iff (rst)
        ld_done_o && ld_fault_o |-> ld_code_o != FLT_NONE);

    p_ok_has_zero_code_r5: assert property (@(posedge clk) disable iff (rst)
        ld_done_o && !ld_fault_o |-> ld_code_o == FLT_NONE);

    p_fault_keeps_regs_r3: assert property (@(posedge clk) disable iff (rst)
        ld_done_o && ld_fault_o |-> bank == $past(bank));

    p_writeback_marks_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o |-> mem_wdata_o[ACC_BIT]);

    p_success_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        ld_done_o && !ld_fault_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        ld_done_o |=> !ld_done_o);

    p_req_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> ld_busy_o);

    p_invalid_refused_r10: assert property (@(posedge clk) disable iff (rst)
        !seg_valid_o |-> !acc_ok_o);

endmodule

bind seg_load_unit seg_load_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_done_o   (ld_done_o),
    .ld_fault_o  (ld_fault_o),
    .ld_code_o   (ld_code_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .ld_busy_o   (ld_busy_o),
    .acc_ok_o    (acc_ok_o),
    .seg_valid_o (seg_valid_o),
    .bank        (bank_all)
);

// File: tb/sim_seg_load_unit.sv
module sim_seg_load_unit;

    localparam int NSEG = 6;
    localparam int GW   = 64;
    localparam int LW   = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [31:0] gdt_base = 32'h100;
    logic [31:0] ldt_base = 32'h200;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic        ld_busy, ld_done, ld_fault;
    logic [1:0]  ld_code;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [2:0]  acc_seg = '0;
    logic [31:0] acc_off = '0;
    logic        acc_ok, seg_valid;
    logic [31:0] acc_lin, seg_base, seg_limit;
    logic [15:0] seg_sel;
    logic [1:0]  cpl;

    seg_load_unit #(.NUM_SEG(NSEG)) u0 (
        .clk(clk), .rst(rst), .gdt_base_i(gdt_base), .ldt_base_i(ldt_base),
        .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
        .ld_busy_o(ld_busy), .ld_done_o(ld_done), .ld_fault_o(ld_fault), .ld_code_o(ld_code),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .acc_seg_i(acc_seg), .acc_off_i(acc_off), .acc_ok_o(acc_ok), .acc_lin_o(acc_lin),
        .seg_valid_o(seg_valid), .seg_sel_o(seg_sel), .seg_base_o(seg_base),
        .seg_limit_o(seg_limit), .cpl_o(cpl)
    );

    // Memory model with random wait states; preload path for the bench.
    logic [31:0] mem [256];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_idx = '0;
    logic [31:0] pl_data = '0;
    int unsigned wcnt = 0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (pl_en) begin
            mem[pl_idx] <= pl_data;
        end else if (mem_req && !mem_ack) begin
            if (wcnt == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
                wcnt <= $urandom_range(2, 0);
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        e_valid [NSEG];
    logic [15:0] e_sel   [NSEG];
    logic [31:0] e_base  [NSEG];
    logic [31:0] e_span  [NSEG];
    logic        e_down  [NSEG];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
        return {b[15:0], l[15:0]};
    endfunction

    function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                          input logic g, input logic p, input logic [1:0] dpl,
                                          input logic s, input logic [3:0] typ);
        return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, dpl, s, typ, b[23:16]};
    endfunction

    function automatic int word_of(input logic ti, input int idx);
        return (ti ? LW : GW) + idx * 2;
    endfunction

    task automatic preload(input int w, input logic [31:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = 8'(w); pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic put_desc(input logic ti, input int idx, input logic [31:0] b,
                            input logic [19:0] l, input logic g, input logic p,
                            input logic [1:0] dpl, input logic s, input logic [3:0] typ);
        preload(word_of(ti, idx), mk_lo(b, l));
        preload(word_of(ti, idx) + 1, mk_hi(b, l, g, p, dpl, s, typ));
    endtask

    task automatic readback(input int seg);
        @(negedge clk);
        acc_seg = 3'(seg);
        #1;
        chk("R5 valid", 32'(seg_valid), 32'(e_valid[seg]));
        chk("R5 selector", 32'(seg_sel), 32'(e_sel[seg]));
        chk("R2 base", seg_base, e_base[seg]);
        chk("R7 limit", seg_limit, e_span[seg]);
        chk("R6 cpl", 32'(cpl), 32'(e_sel[0][1:0]));
    endtask

    // Loads one selector; intrude drives a second request while busy (R11).
    task automatic do_load(input int seg, input logic ti, input int idx,
                           input logic [1:0] rpl, input bit intrude);
        logic [31:0] lo, hi;
        logic [1:0]  eff, exp_code;
        int          w;
        bit          got;
        w  = word_of(ti, idx);
        lo = mem[w];
        hi = mem[w + 1];
        eff = (e_sel[0][1:0] > rpl) ? e_sel[0][1:0] : rpl;
        if (!hi[15])             exp_code = 2'd1;
        else if (eff > hi[14:13]) exp_code = 2'd2;
        else                      exp_code = 2'd0;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'(seg); ld_sel = {13'(idx), ti, rpl};
        @(negedge clk);
        ld_valid = 1'b0;
        got = 0;
        for (int k = 0; k < 60 && !got; k++) begin
            if (intrude && k == 0) begin
                ld_valid = 1'b1; ld_seg = 3'd4; ld_sel = 16'hFFFB;
            end else begin
                ld_valid = 1'b0;
            end
            @(negedge clk);
            if (ld_done) got = 1;
        end
        ld_valid = 1'b0;
        chk("R1 load completes", 32'(got), 32'd1);
        if (exp_code == 2'd1)      chk("R3 code", 32'(ld_code), 32'(exp_code));
        else if (exp_code == 2'd2) chk("R4 code", 32'(ld_code), 32'(exp_code));
        else                       chk("R5 code", 32'(ld_code), 32'(exp_code));
        chk("R5 fault flag", 32'(ld_fault), 32'(exp_code != 2'd0));
        if (exp_code == 2'd0) begin
            chk("R5 accessed written", mem[w + 1], hi | 32'h100);
            chk("R1 low word intact", mem[w], lo);
            e_valid[seg] = 1'b1;
            e_sel[seg]   = {13'(idx), ti, rpl};
            e_base[seg]  = {hi[31:24], hi[7:0], lo[31:16]};
            e_span[seg]  = hi[23] ? {hi[19:16], lo[15:0], 12'hFFF}
                                  : {12'h0, hi[19:16], lo[15:0]};
            e_down[seg]  = hi[12] && !hi[11] && hi[10];
        end else begin
            chk("R3 memory unchanged", mem[w + 1], hi);
        end
        readback(seg);
    endtask

    task automatic chk_acc(input int seg, input logic [31:0] off);
        logic eok;
        @(negedge clk);
        acc_seg = 3'(seg); acc_off = off;
        #1;
        if (!e_valid[seg])    eok = 1'b0;
        else if (e_down[seg]) eok = (off > e_span[seg]);
        else                  eok = (off <= e_span[seg]);
        if (e_down[seg]) chk("R9 grows-down check", 32'(acc_ok), 32'(eok));
        else             chk("R8 limit check", 32'(acc_ok), 32'(eok));
        if (e_valid[seg]) chk("R8 linear", acc_lin, e_base[seg] + off);
    endtask

    task automatic quiet_window(input string req);
        int seen;
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (ld_busy || ld_done) seen++;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!finished) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] b;
        logic [19:0] l;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NSEG; i++) begin
            e_valid[i] = 0; e_sel[i] = '0; e_base[i] = '0; e_span[i] = '0; e_down[i] = 0;
        end
        for (int i = 0; i < 256; i++) preload(i, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: state after reset
        chk("R10 busy", 32'(ld_busy), 32'd0);
        chk("R10 done", 32'(ld_done), 32'd0);
        for (int s = 0; s < NSEG; s++) begin
            @(negedge clk);
            acc_seg = 3'(s); acc_off = 32'h0;
            #1;
            chk("R10 invalid", 32'(seg_valid), 32'd0);
            chk("R10 refused", 32'(acc_ok), 32'd0);
        end
        chk("R6 reset cpl", 32'(cpl), 32'd0);

        // R1, R2, R5, R8: global entry, byte limit
        put_desc(1'b0, 3, 32'h1234_5678, 20'h00FFF, 1'b0, 1'b1, 2'd3, 1'b1, 4'b0010);
        do_load(3, 1'b0, 3, 2'd0, 0);
        chk_acc(3, 32'h0000_0FFF);
        chk_acc(3, 32'h0000_1000);

        // R7: local entry, page granular limit
        put_desc(1'b1, 5, 32'hA000_0000, 20'h00002, 1'b1, 1'b1, 2'd0, 1'b1, 4'b0010);
        do_load(2, 1'b1, 5, 2'd0, 0);
        chk_acc(2, 32'h0000_2FFF);
        chk_acc(2, 32'h0000_3000);

        // R9: grows-down segment
        put_desc(1'b0, 7, 32'h0001_0000, 20'h00010, 1'b0, 1'b1, 2'd3, 1'b1, 4'b0110);
        do_load(1, 1'b0, 7, 2'd0, 0);
        chk_acc(1, 32'h0000_0010);
        chk_acc(1, 32'h0000_0011);
        chk_acc(1, 32'hFFFF_FFFF);

        // R3: absent descriptor leaves register 3 as loaded before
        put_desc(1'b0, 9, 32'h5555_0000, 20'h00100, 1'b0, 1'b0, 2'd3, 1'b1, 4'b0010);
        do_load(3, 1'b0, 9, 2'd0, 0);

        // R4: requester level 3 against descriptor level 0
        put_desc(1'b0, 10, 32'h6666_0000, 20'h00100, 1'b0, 1'b1, 2'd0, 1'b1, 4'b0010);
        do_load(5, 1'b0, 10, 2'd3, 0);

        // R3 priority over R4
        put_desc(1'b0, 11, 32'h7777_0000, 20'h00100, 1'b0, 1'b0, 2'd0, 1'b1, 4'b0010);
        do_load(5, 1'b0, 11, 2'd3, 0);

        // R6: code register load raises the current level to 2
        put_desc(1'b0, 12, 32'h0000_8000, 20'h0FFFF, 1'b0, 1'b1, 2'd2, 1'b1, 4'b1010);
        do_load(0, 1'b0, 12, 2'd2, 0);
        put_desc(1'b0, 13, 32'h0000_9000, 20'h00FFF, 1'b0, 1'b1, 2'd1, 1'b1, 4'b0010);
        do_load(4, 1'b0, 13, 2'd0, 0);
        put_desc(1'b0, 14, 32'h0000_A000, 20'h00FFF, 1'b0, 1'b1, 2'd3, 1'b1, 4'b0010);
        do_load(4, 1'b0, 14, 2'd0, 0);

        // R11: second request while busy is dropped
        put_desc(1'b1, 2, 32'h0BAD_0000, 20'h00FFF, 1'b0, 1'b1, 2'd3, 1'b1, 4'b0010);
        do_load(3, 1'b1, 2, 2'd3, 1);
        quiet_window("R11 no second load");
        readback(4);

        // R12: target index out of range
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd6; ld_sel = {13'd3, 1'b0, 2'd3};
        @(negedge clk);
        ld_valid = 1'b0;
        quiet_window("R12 ignored target 6");
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd7;
        @(negedge clk);
        ld_valid = 1'b0;
        quiet_window("R12 ignored target 7");

        // Random phase
        for (int it = 0; it < 80; it++) begin
            int s, idx;
            logic ti;
            logic [1:0] rpl;
            s   = $urandom_range(NSEG - 1, 0);
            ti  = 1'($urandom_range(1, 0));
            idx = $urandom_range(15, 0);
            rpl = 2'($urandom_range(3, 0));
            if ($urandom_range(3, 0) != 0) begin
                b = $urandom;
                l = 20'($urandom);
                put_desc(ti, idx, b, l, 1'($urandom_range(1, 0)),
                         ($urandom_range(4, 0) != 0), 2'($urandom_range(3, 0)),
                         ($urandom_range(5, 0) != 0), {3'($urandom_range(7, 0)), 1'b0});
            end
            if (s == 0 && $urandom_range(1, 0) == 1) rpl = 2'd0;
            do_load(s, ti, idx, rpl, 0);
            chk_acc(s, e_span[s]);
            chk_acc(s, e_span[s] + 32'd1);
            chk_acc(s, e_span[s] - 32'd1);
            chk_acc(s, $urandom);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule